// File: doc/BRIEF.md
# Mu-law Companding Register Engine

This block converts between 8-bit mu-law codes and 16-bit two's-complement linear samples behind a byte-wide register bus. It has one configuration register and two data registers that hold the high and low bytes of a sample. While the audio path is switched off, a write to the high data register starts a conversion that runs on its own. That conversion is either an expansion of the written code or a compression of the assembled 16-bit sample. The result sits in the data registers one clock later, and a one-cycle done strobe marks it.

While the audio path is switched on, the block sits between software and the serial audio logic. A byte written to the high data register is sent to the transmit side as a 16-bit sample, and it is expanded first if expansion is selected. A sample that arrives from the receive side is written into the data registers, and it is compressed into the high byte first if compression is selected. Framing and bit clocking belong to the serial logic. Here they are reduced to a valid strobe in each direction.

Top module: `ulaw_engine`

## Requirements
- R1: After a synchronous reset the configuration register, both data registers, `done` and `tx_valid` are all zero, so the audio path starts disabled.
- R2: Register addresses: 0 = configuration, with bit 0 = audio enable, bit 1 = expand select, bit 2 = compress select, and bits 7..3 reading 0. Address 1 = low data byte. Address 2 = high data byte. Address 3 reads 0 and ignores writes. `rd_data` shows the register chosen by `rd_addr` one cycle later. A read in the same cycle as a write returns the contents from before that write.
- R3: Audio disabled, expand=1, compress=0: writing a code to the high byte leaves the expanded 16-bit sample in high:low on the next cycle, and `done` is high for exactly that one cycle.
- R4: Audio disabled, expand=0, compress=1: the low byte is written first, and then the write to the high byte compresses {written high, low}. On the next cycle the high byte holds the code, the low byte keeps its written value, and `done` pulses for one cycle.
- R5: Compression works as follows. Take the sign. Limit the magnitude to 32635 and add 132. The segment is the position of the leading one within bits 14..7, minus 7. The 4-bit mantissa is the next four bits below it. The code is the bitwise inverse of {sign, segment[2:0], mantissa[3:0]}. So 0 maps to 0xFF, 32767 maps to 0x80, -32768 maps to 0x00 and 1000 maps to 0xCE.
- R6: Expansion inverts the code and computes (((mantissa*8)+132) << segment) - 132, then negates the result if the sign bit is set. Expanding any code and compressing the result returns the same code, except that 0x7F and 0xFF both expand to 0, which compresses to 0xFF.
- R7: Audio disabled with both selects set, or with neither set: a high-byte write only stores the byte, and `done` stays low.
- R8: Audio enabled: a high-byte write raises `tx_valid` for one cycle on the next clock. `tx_sample` is then the expansion of the byte if expand is set, and {written byte, low register} if it is not. `done` stays low.
- R9: Audio enabled with `rx_valid`: on the next cycle the high byte holds the compressed code and the low byte is unchanged if compress is set. If compress is not set, high:low holds the sample.
- R10: `rx_valid` is ignored while audio is disabled. It is also dropped when any register write happens in the same cycle, and the write takes effect instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| done | output | 1 | Standalone conversion complete, one-cycle pulse |
| rx_valid | input | 1 | Received sample strobe |
| rx_sample | input | 16 | Received linear sample |
| tx_valid | output | 1 | Outgoing sample strobe |
| tx_sample | output | 16 | Outgoing linear sample |

## Verification
The assertions check on every cycle that each `done` pulse comes from a qualifying high-byte write in standalone mode, and that each `tx_valid` comes from a high-byte write with audio enabled. They also check that a disabled or pre-empted receive strobe leaves the data registers untouched, that a compression keeps the low byte, and that an ambiguous flag setting only stores the byte. The arithmetic itself can only be shown by the bench scenarios. These include the full 256-code expand-then-compress round trip, fixed compression points at the clipping limits, the transmit and receive data values, and the way a read in the same cycle as a write sees the old contents.

// File: rtl/ulaw_pkg.sv
`timescale 1ns/1ps
package ulaw_pkg;
  localparam int BYTE_W = 8;
  localparam int LIN_W  = 16;
  localparam int CFG_W  = 3;
  localparam int SEG_W  = 3;
  localparam int MANT_W = 4;
  localparam int CLIP   = 32635;
  localparam int BIAS   = 132;

  localparam int CFG_EN  = 0;
  localparam int CFG_EXP = 1;
  localparam int CFG_CMP = 2;

  localparam int ADR_CFG = 0;
  localparam int ADR_LO  = 1;
  localparam int ADR_HI  = 2;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_CFG,
    ACT_LO,
    ACT_STORE_HI,
    ACT_EXPAND,
    ACT_COMPRESS,
    ACT_RX
  } act_e;
endpackage

// File: rtl/ulaw_compress.sv
`timescale 1ns/1ps
module ulaw_compress
  import ulaw_pkg::*;
#(
  parameter int LW = LIN_W,
  parameter int CW = BYTE_W
) (
  input  logic [LW-1:0] lin,
  output logic [CW-1:0] code
);
  localparam int MW  = LW + 1;
  localparam int BW  = LW - 1;
  localparam int NSEG = 1 << SEG_W;
  localparam int SEG_BASE = BW - NSEG;

  logic          sgn;
  logic [MW-1:0] mag;
  logic [BW-1:0] biased;
  logic [BW-1:0] shifted;
  logic [SEG_W-1:0] seg;

  always_comb begin
    sgn = lin[LW-1];
    mag = sgn ? (MW'(0) - {lin[LW-1], lin}) : {1'b0, lin};
    if (mag > MW'(CLIP)) mag = MW'(CLIP);
    biased = BW'(mag[BW-1:0] + BW'(BIAS));
    seg = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (biased[SEG_BASE + i]) seg = SEG_W'(i);
    end
    shifted = biased >> (5'(seg) + 5'(SEG_BASE - MANT_W));
    code = ~{sgn, seg, shifted[MANT_W-1:0]};
  end
endmodule

// File: rtl/ulaw_expand.sv
`timescale 1ns/1ps
module ulaw_expand
  import ulaw_pkg::*;
#(
  parameter int LW = LIN_W,
  parameter int CW = BYTE_W
) (
  input  logic [CW-1:0] code,
  output logic [LW-1:0] lin
);
  localparam int BW = LW - 1;

  logic [CW-1:0]     inv;
  logic [BW-1:0]     base;
  logic [BW-1:0]     scaled;
  logic [BW-1:0]     mag;

  always_comb begin
    inv    = ~code;
    base   = BW'({inv[MANT_W-1:0], 3'b000}) + BW'(BIAS);
    scaled = base << inv[MANT_W +: SEG_W];
    mag    = scaled - BW'(BIAS);
    lin    = inv[CW-1] ? (LW'(0) - {1'b0, mag}) : {1'b0, mag};
  end
endmodule

// File: rtl/ulaw_decode.sv
`timescale 1ns/1ps
module ulaw_decode
  import ulaw_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CFG_W-1:0] cfg,
  input  logic          rx_valid,
  output act_e          act,
  output logic          tx_fire
);
  always_comb begin
    act     = ACT_IDLE;
    tx_fire = 1'b0;
    if (wr_en) begin
      if (wr_addr == AW'(ADR_CFG)) begin
        act = ACT_CFG;
      end else if (wr_addr == AW'(ADR_LO)) begin
        act = ACT_LO;
      end else if (wr_addr == AW'(ADR_HI)) begin
        if (cfg[CFG_EN]) begin
          act     = ACT_STORE_HI;
          tx_fire = 1'b1;
        end else if (cfg[CFG_EXP] && !cfg[CFG_CMP]) begin
          act = ACT_EXPAND;
        end else if (!cfg[CFG_EXP] && cfg[CFG_CMP]) begin
          act = ACT_COMPRESS;
        end else begin
          act = ACT_STORE_HI;
        end
      end
    end else if (rx_valid && cfg[CFG_EN]) begin
      act = ACT_RX;
    end
  end
endmodule

// File: rtl/ulaw_engine.sv
`timescale 1ns/1ps
module ulaw_engine
  import ulaw_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DW     = BYTE_W,
  parameter int SW     = LIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              done,
  input  logic              rx_valid,
  input  logic [SW-1:0]     rx_sample,
  output logic              tx_valid,
  output logic [SW-1:0]     tx_sample
);
  logic [CFG_W-1:0] cfg_q;
  logic [DW-1:0]    hi_q, lo_q, rd_q;
  logic             done_q, tx_valid_q;
  logic [SW-1:0]    tx_sample_q;

  act_e             act;
  logic             tx_fire;
  logic [SW-1:0]    cmp_in, exp_out;
  logic [DW-1:0]    cmp_out;
  logic [DW-1:0]    rd_mux;

  ulaw_decode #(.AW(ADDR_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .cfg(cfg_q),
    .rx_valid(rx_valid), .act(act), .tx_fire(tx_fire)
  );

  assign cmp_in = (act == ACT_COMPRESS) ? {wr_data, lo_q} : rx_sample;

  ulaw_compress #(.LW(SW), .CW(DW)) u_cmp (.lin(cmp_in), .code(cmp_out));
  ulaw_expand   #(.LW(SW), .CW(DW)) u_exp (.code(wr_data), .lin(exp_out));

  always_comb begin
    if (rd_addr == ADDR_W'(ADR_CFG))     rd_mux = DW'(cfg_q);
    else if (rd_addr == ADDR_W'(ADR_LO)) rd_mux = lo_q;
    else if (rd_addr == ADDR_W'(ADR_HI)) rd_mux = hi_q;
    else                                 rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      hi_q        <= '0;
      lo_q        <= '0;
      rd_q        <= '0;
      done_q      <= 1'b0;
      tx_valid_q  <= 1'b0;
      tx_sample_q <= '0;
    end else begin
      rd_q       <= rd_mux;
      done_q     <= (act == ACT_EXPAND) || (act == ACT_COMPRESS);
      tx_valid_q <= tx_fire;
      if (tx_fire)
        tx_sample_q <= cfg_q[CFG_EXP] ? exp_out : {wr_data, lo_q};
      case (act)
        ACT_CFG:      cfg_q <= wr_data[CFG_W-1:0];
        ACT_LO:       lo_q  <= wr_data;
        ACT_STORE_HI: hi_q  <= wr_data;
        ACT_EXPAND:   {hi_q, lo_q} <= exp_out;
        ACT_COMPRESS: hi_q  <= cmp_out;
        ACT_RX: begin
          if (cfg_q[CFG_CMP]) hi_q <= cmp_out;
          else                {hi_q, lo_q} <= rx_sample;
        end
        default: ;
      endcase
    end
  end

  assign rd_data   = rd_q;
  assign done      = done_q;
  assign tx_valid  = tx_valid_q;
  assign tx_sample = tx_sample_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !done_q && !tx_valid_q && hi_q == '0 && lo_q == '0));

  p_done_source_r3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(wr_en && wr_addr == ADDR_W'(ADR_HI) && !cfg_q[CFG_EN]
                     && (cfg_q[CFG_EXP] ^ cfg_q[CFG_CMP])));

  p_compress_keeps_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADR_HI) && !cfg_q[CFG_EN] && !cfg_q[CFG_EXP]
     && cfg_q[CFG_CMP]) |=> $stable(lo_q));

  p_ambiguous_store_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(ADR_HI) && !cfg_q[CFG_EN]
     && (cfg_q[CFG_EXP] == cfg_q[CFG_CMP])) |=> (hi_q == $past(wr_data) && !done_q));

  p_tx_source_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid_q |-> $past(wr_en && wr_addr == ADDR_W'(ADR_HI) && cfg_q[CFG_EN]));

  p_rx_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !cfg_q[CFG_EN] && !wr_en) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: tb/ulaw_engine_test.sv
`timescale 1ns/1ps
module ulaw_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        done;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_sample = '0;
  logic        tx_valid;
  logic [15:0] tx_sample;

  int errors = 0;
  int checks = 0;
  logic        got_done, got_tx;
  logic [15:0] got_txs;

  always #10 clk = ~clk;

  ulaw_engine uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .rx_valid(rx_valid),
    .rx_sample(rx_sample), .tx_valid(tx_valid), .tx_sample(tx_sample)
  );

  function automatic logic [15:0] model_expand(input logic [7:0] code);
    int c, s, e, m, mag;
    c = int'(~code) & 255;
    s = c / 128;
    e = (c / 16) % 8;
    m = c % 16;
    mag = ((m * 8 + 132) * (1 << e)) - 132;
    return 16'(s != 0 ? -mag : mag);
  endfunction

  function automatic logic [7:0] model_compress(input int x);
    int s, mag, e, m;
    bit found;
    s = (x < 0) ? 1 : 0;
    mag = (x < 0) ? -x : x;
    if (mag > 32635) mag = 32635;
    mag = mag + 132;
    e = 0;
    found = 0;
    for (int k = 7; k >= 0; k--) begin
      if (!found && mag >= (128 << k)) begin
        e = k;
        found = 1;
      end
    end
    m = (mag >> (e + 3)) % 16;
    return ~8'(s * 128 + e * 16 + m);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    got_done = done; got_tx = tx_valid; got_txs = tx_sample;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic rx(input logic [15:0] s);
    @(negedge clk);
    rx_valid = 1'b1; rx_sample = s;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 done", int'(done), 0);
    check("R1 tx_valid", int'(tx_valid), 0);
    rd(2'd0, v); check("R1 cfg", v, 0);
    rd(2'd1, v); check("R1 lo", v, 0);
    rd(2'd2, v); check("R1 hi", v, 0);
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 cfg upper bits", v, 8'h07);
    wr(2'd3, 8'h55); rd(2'd3, v); check("R2 addr3", v, 0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h3C); rd(2'd1, v); check("R2 lo rw", v, 8'h3C);
    // same-cycle read and write of the high byte sees the old value
    wr(2'd2, 8'h11);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h99; rd_addr = 2'd2;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 read before write", rd_data, 8'h11);
    @(negedge clk);
    check("R2 read after write", rd_data, 8'h99);
  endtask

  task automatic t_round_trip();
    logic [7:0] h, l;
    logic [15:0] lin;
    for (int c = 0; c < 256; c++) begin
      wr(2'd0, 8'h02);
      wr(2'd2, 8'(c));
      check("R3 done pulse", int'(got_done), 1);
      rd(2'd2, h); rd(2'd1, l);
      check("R3 done one cycle", int'(done), 0);
      lin = {h, l};
      check("R6 expand value", lin, model_expand(8'(c)));
      wr(2'd0, 8'h04);
      wr(2'd1, l);
      wr(2'd2, h);
      check("R4 done pulse", int'(got_done), 1);
      rd(2'd2, h);
      check("R6 round trip", h, (c == 8'h7F) ? 8'hFF : c);
      rd(2'd1, l);
      check("R4 lo kept", l, lin[7:0]);
    end
  endtask

  task automatic t_compress_points();
    logic [7:0] h;
    int pts [6] = '{0, 32767, -32768, 1000, -1000, 200};
    int fixed [4] = '{8'hFF, 8'h80, 8'h00, 8'hCE};
    wr(2'd0, 8'h04);
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, 8'(pts[i]));
      wr(2'd2, 8'(pts[i] >>> 8));
      rd(2'd2, h);
      check("R5 compress", h, model_compress(pts[i]));
      if (i < 4) check("R5 fixed point", h, fixed[i]);
    end
  endtask

  task automatic t_ambiguous();
    logic [7:0] h;
    wr(2'd0, 8'h06);
    wr(2'd2, 8'h5A);
    check("R7 no done both", int'(got_done), 0);
    rd(2'd2, h); check("R7 stored both", h, 8'h5A);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hA5);
    check("R7 no done neither", int'(got_done), 0);
    rd(2'd2, h); check("R7 stored neither", h, 8'hA5);
  endtask

  task automatic t_tx();
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h80);
    check("R8 tx_valid", int'(got_tx), 1);
    check("R8 tx expanded", got_txs, model_expand(8'h80));
    check("R8 no done", int'(got_done), 0);
    @(negedge clk);
    check("R8 tx one cycle", int'(tx_valid), 0);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h12);
    check("R8 tx raw", got_txs, 16'h1234);
  endtask

  task automatic t_rx();
    logic [7:0] h, l;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h77);
    rx(16'd1000);
    rd(2'd2, h); rd(2'd1, l);
    check("R9 rx compressed", h, 8'hCE);
    check("R9 lo unchanged", l, 8'h77);
    wr(2'd0, 8'h01);
    rx(16'hBEEF);
    rd(2'd2, h); rd(2'd1, l);
    check("R9 rx raw", {h, l}, 16'hBEEF);
    wr(2'd0, 8'h04);
    rx(16'h1357);
    rd(2'd2, h); rd(2'd1, l);
    check("R10 rx ignored disabled", {h, l}, 16'hBEEF);
    wr(2'd0, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h11;
    rx_valid = 1'b1; rx_sample = 16'h2222;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    rd(2'd2, h); rd(2'd1, l);
    check("R10 write wins", {h, l}, 16'hBE11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_compress_points();
    t_ambiguous();
    t_tx();
    t_rx();
    t_round_trip();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule